// File: doc/BRIEF.md
# Flash Line Accelerator

This block sits between a 32-bit processor read port and a slow flash array that delivers 128-bit lines covering aligned 16-byte blocks. It keeps four single-line registers:

- a current instruction line and a next instruction line, which together form the prefetch stage;
- a jump line, which keeps the block reached by the most recent non-sequential instruction fetch;
- a data line, which serves non-instruction reads.

A word read whose block is already held completes in the same cycle. A read that misses holds the ready signal low until the flash line arrives.

The flash access time is given in processor clocks on a configuration input and is sampled when each access starts. Only one flash access runs at a time. When no demand is waiting, the block asks for the line that follows the current instruction line, so straight-line code keeps running while the flash works. Clearing the enable input empties every line register and sends every read to the flash.

Top module: `flash_line_accel`

## Requirements
- R1: A flash access is a single-cycle `fl_req` pulse carrying the line address, which is the read address shifted right by 4. With an access time of T clocks, the line is taken from `fl_rdata` in the T-th cycle counting the request cycle. No new request is made before that cycle has passed.
- R2: A read that misses every line register, presented while no flash access is running, raises `rd_ready` exactly T-1 cycles after it is first presented. With T = 3 that is 2 wait states.
- R3: An instruction read whose line is held in the current, next or jump line register gets `rd_ready` in the cycle it is presented, and it causes no flash request.
- R4: `rd_data` is word `rd_addr[3:2]` of the line, where word 0 is bits [31:0] of `fl_rdata`.
- R5: While the block is enabled and no demand is waiting, it requests the line after the current instruction line. With T = 3, a sequential fetch stream that crosses line boundaries runs with no wait states after its first line.
- R6: A data read (`rd_is_instr` = 0) to the same line as the previous data read completes with no wait. Data reads never fill the instruction line registers.
- R7: The jump line keeps the line of the most recent non-sequential instruction fetch (`rd_is_seq` = 0). A later jump to that line completes with no wait. Once a jump to another line has replaced it, a jump to the earlier line misses.
- R8: A demand miss that arrives while a prefetch of a different line is running waits until that prefetch's data cycle. Its own request follows in the next cycle. With T = 3, a demand presented one cycle after the prefetch request sees 4 wait states.
- R9: A demand miss to the line that is being prefetched makes no new request. It completes in that prefetch's data cycle.
- R10: While `cfg_enable` is low, every read goes to the flash and no prefetch is issued. All line registers are emptied, so they miss again after the block is re-enabled.
- R11: During reset `rd_ready` and `fl_req` are low. After reset all line registers are empty.
- R12: The access time is programmable. With T = 5, a miss costs 4 wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | 1: line registers in use; 0: every read goes to the flash |
| cfg_access_clks | input | 4 | Flash access time T in clocks, 2 or more |
| rd_valid | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | 32 | Word-aligned byte address |
| rd_is_instr | input | 1 | 1: instruction fetch; 0: data read |
| rd_is_seq | input | 1 | 1: sequential fetch; 0: jump (non-sequential) |
| rd_data | output | 32 | Read word, valid while `rd_ready` is high |
| rd_ready | output | 1 | The read completes this cycle |
| fl_req | output | 1 | Single-cycle flash access request |
| fl_line_addr | output | 28 | Line address of the request |
| fl_rdata | input | 128 | Flash line, sampled in the data cycle |

## Verification
The assertions assume a requester that holds address, kind and sequential flag stable from the first cycle of a read until `rd_ready`. They assume every address is word-aligned and that the access time is at least 2 clocks. They also assume the flash drives the requested line in the data cycle. The bench keeps to these assumptions: its read task holds the request until ready, it uses only aligned addresses, and it changes the access time and the enable only while the requester is idle and no access is running. Its flash model drives a line pattern derived from the address only in the exact data cycle and drives garbage in every other cycle, so a mistimed capture shows up as wrong data.

// File: rtl/flash_accel_pkg.sv
package flash_accel_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_PREF  = 2'd1,
      ACC_INSTR = 2'd2,
      ACC_DATA  = 2'd3
   } acc_kind_e;

   localparam int NBUF     = 4;
   localparam int BUF_CUR  = 0;
   localparam int BUF_NEXT = 1;
   localparam int BUF_JMP  = 2;
   localparam int BUF_DAT  = 3;
   localparam int N_INSTR_BUF = 3;

endpackage

// File: rtl/accel_line_slot.sv
module accel_line_slot #(
   parameter int TAG_W  = 28,
   parameter int WORDS  = 4,
   parameter int WORD_W = 32,
   localparam int SEL_W  = $clog2(WORDS),
   localparam int LINE_W = WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [LINE_W-1:0] wr_line,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [SEL_W-1:0]  lk_sel,
   output logic              valid_q,
   output logic [TAG_W-1:0]  tag_q,
   output logic [LINE_W-1:0] line_q,
   output logic              hit,
   output logic [WORD_W-1:0] word
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
      end else if (clr) begin
         valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q  <= wr_tag;
         line_q <= wr_line;
      end
   end

   assign hit  = valid_q && (tag_q == lk_tag);
   assign word = line_q[lk_sel*WORD_W +: WORD_W];

endmodule

// File: rtl/accel_flash_seq.sv
module accel_flash_seq
   import flash_accel_pkg::*;
#(
   parameter int TAG_W = 28,
   parameter int TIM_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TIM_W-1:0] cfg_access_clks,
   input  logic             issue_req,
   input  logic [TAG_W-1:0] issue_tag,
   input  acc_kind_e        issue_kind,
   output logic             fl_req,
   output logic [TAG_W-1:0] fl_line_addr,
   output logic             busy,
   output logic             data_cycle,
   output logic [TAG_W-1:0] busy_tag,
   output acc_kind_e        busy_kind
);

   logic [TIM_W-1:0] cnt_q;

   assign fl_req       = issue_req && !busy;
   assign fl_line_addr = issue_tag;
   assign data_cycle   = busy && (cnt_q == TIM_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cnt_q     <= '0;
         busy_tag  <= '0;
         busy_kind <= ACC_NONE;
      end else if (fl_req) begin
         busy      <= 1'b1;
         cnt_q     <= cfg_access_clks - TIM_W'(1);
         busy_tag  <= issue_tag;
         busy_kind <= issue_kind;
      end else if (busy) begin
         cnt_q <= cnt_q - TIM_W'(1);
         if (cnt_q == TIM_W'(1)) begin
            busy      <= 1'b0;
            busy_kind <= ACC_NONE;
         end
      end
   end

   // R1: a request is one cycle wide
   assert_req_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |=> !fl_req);

   // R1: an access stays open until its data cycle
   assert_one_outstanding_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !data_cycle) |=> busy);

   // R12: the access time must allow a separate data cycle
   assert_cfg_min_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fl_req |-> (cfg_access_clks >= TIM_W'(2)));

endmodule

// File: rtl/flash_line_accel.sv
module flash_line_accel
   import flash_accel_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter int WORD_W         = 32,
   parameter int WORDS_PER_LINE = 4,
   parameter int TIM_W          = 4,
   localparam int SEL_W      = $clog2(WORDS_PER_LINE),
   localparam int BYTE_SEL_W = $clog2(WORD_W / 8),
   localparam int OFF_W      = SEL_W + BYTE_SEL_W,
   localparam int TAG_W      = ADDR_W - OFF_W,
   localparam int LINE_W     = WORD_W * WORDS_PER_LINE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [TIM_W-1:0]  cfg_access_clks,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_is_instr,
   input  logic              rd_is_seq,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_ready,
   output logic              fl_req,
   output logic [TAG_W-1:0]  fl_line_addr,
   input  logic [LINE_W-1:0] fl_rdata
);

   // elaboration-time parameter checks
   if (WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
      $error("WORD_W must be a multiple of 8 and at least 16");
   end
   if (WORDS_PER_LINE < 2 || (WORDS_PER_LINE & (WORDS_PER_LINE - 1)) != 0) begin : g_bad_line
      $error("WORDS_PER_LINE must be a power of two, 2 or more");
   end
   if (TIM_W < 2 || TAG_W < 1) begin : g_bad_width
      $error("TIM_W must be at least 2 and ADDR_W must exceed the line offset");
   end

   // request decode
   logic [TAG_W-1:0] rd_tag;
   logic [SEL_W-1:0] rd_sel;
   assign rd_tag = rd_addr[ADDR_W-1:OFF_W];
   assign rd_sel = rd_addr[OFF_W-1:BYTE_SEL_W];

   // flash sequencer
   logic             issue_req;
   logic [TAG_W-1:0] issue_tag;
   acc_kind_e        issue_kind;
   logic             busy;
   logic             data_cycle;
   logic [TAG_W-1:0] busy_tag;
   acc_kind_e        busy_kind;

   accel_flash_seq #(
      .TAG_W (TAG_W),
      .TIM_W (TIM_W)
   ) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_access_clks (cfg_access_clks),
      .issue_req       (issue_req),
      .issue_tag       (issue_tag),
      .issue_kind      (issue_kind),
      .fl_req          (fl_req),
      .fl_line_addr    (fl_line_addr),
      .busy            (busy),
      .data_cycle      (data_cycle),
      .busy_tag        (busy_tag),
      .busy_kind       (busy_kind)
   );

   // line registers
   logic [NBUF-1:0]   slot_valid;
   logic [NBUF-1:0]   slot_hit;
   logic [NBUF-1:0]   slot_wr;
   logic [NBUF-1:0]   slot_clr;
   logic [TAG_W-1:0]  slot_tag   [NBUF];
   logic [LINE_W-1:0] slot_line  [NBUF];
   logic [WORD_W-1:0] slot_word  [NBUF];
   logic [LINE_W-1:0] served_line;

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      logic [TAG_W-1:0]  wtag;
      logic [LINE_W-1:0] wline;
      if (g == BUF_NEXT) begin : g_pref_src
         assign wtag  = busy_tag;
         assign wline = fl_rdata;
      end else begin : g_dem_src
         assign wtag  = rd_tag;
         assign wline = served_line;
      end

      accel_line_slot #(
         .TAG_W  (TAG_W),
         .WORDS  (WORDS_PER_LINE),
         .WORD_W (WORD_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (slot_clr[g]),
         .wr_en   (slot_wr[g]),
         .wr_tag  (wtag),
         .wr_line (wline),
         .lk_tag  (rd_tag),
         .lk_sel  (rd_sel),
         .valid_q (slot_valid[g]),
         .tag_q   (slot_tag[g]),
         .line_q  (slot_line[g]),
         .hit     (slot_hit[g]),
         .word    (slot_word[g])
      );
   end

   // hit detection and read return
   logic instr_hit;
   logic data_hit;
   logic buf_hit;
   logic fill_serve;

   assign instr_hit  = cfg_enable && rd_is_instr && (|slot_hit[N_INSTR_BUF-1:0]);
   assign data_hit   = cfg_enable && !rd_is_instr && slot_hit[BUF_DAT];
   assign buf_hit    = rd_valid && (instr_hit || data_hit);
   assign fill_serve = rd_valid && data_cycle && (busy_tag == rd_tag);
   assign rd_ready   = buf_hit || fill_serve;

   always_comb begin
      rd_data     = fl_rdata[rd_sel*WORD_W +: WORD_W];
      served_line = fl_rdata;
      if (instr_hit) begin
         if (slot_hit[BUF_CUR]) begin
            rd_data     = slot_word[BUF_CUR];
            served_line = slot_line[BUF_CUR];
         end else if (slot_hit[BUF_NEXT]) begin
            rd_data     = slot_word[BUF_NEXT];
            served_line = slot_line[BUF_NEXT];
         end else begin
            rd_data     = slot_word[BUF_JMP];
            served_line = slot_line[BUF_JMP];
         end
      end else if (data_hit) begin
         rd_data     = slot_word[BUF_DAT];
         served_line = slot_line[BUF_DAT];
      end
   end

   // line register updates
   logic srv_en;
   logic srv_instr;
   assign srv_en    = rd_ready && cfg_enable;
   assign srv_instr = srv_en && rd_is_instr;

   always_comb begin
      slot_wr           = '0;
      slot_clr          = {NBUF{!cfg_enable}};
      slot_wr[BUF_CUR]  = srv_instr;
      slot_wr[BUF_JMP]  = srv_instr && !rd_is_seq;
      slot_wr[BUF_DAT]  = srv_en && !rd_is_instr;
      slot_wr[BUF_NEXT] = cfg_enable && data_cycle && (busy_kind == ACC_PREF)
                          && !(srv_instr && (busy_tag == rd_tag));
      slot_clr[BUF_NEXT] = !cfg_enable || (srv_instr && slot_hit[BUF_NEXT]);
   end

   // request selection: a waiting demand beats the next-line prefetch
   logic [TAG_W-1:0] pf_target;
   logic             pf_held;
   logic             want_pf;
   logic             demand_miss;

   assign pf_target = slot_tag[BUF_CUR] + TAG_W'(1);

   always_comb begin
      pf_held = 1'b0;
      for (int i = 0; i < N_INSTR_BUF; i++) begin
         if (slot_valid[i] && (slot_tag[i] == pf_target)) pf_held = 1'b1;
      end
   end

   assign demand_miss = rd_valid && !rd_ready;
   assign want_pf     = cfg_enable && slot_valid[BUF_CUR] && !pf_held;
   assign issue_req   = demand_miss || want_pf;
   assign issue_tag   = demand_miss ? rd_tag : pf_target;
   assign issue_kind  = demand_miss ? (rd_is_instr ? ACC_INSTR : ACC_DATA) : ACC_PREF;

   // R2: the requester holds a read until it completes
   assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)
                                   && $stable(rd_is_instr) && $stable(rd_is_seq)));

   // R4: addresses are word-aligned
   assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_addr[BYTE_SEL_W-1:0] == '0));

   // R10: no flash request without a waiting demand while disabled
   assert_off_no_prefetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_req && !cfg_enable) |-> (rd_valid && !rd_ready));

   // R10: disabling empties every line register
   assert_off_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_enable |=> (slot_valid == '0));

   // R6: a completed data fill lands in the data line register
   assert_data_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_cycle && busy_kind == ACC_DATA && cfg_enable && rd_ready)
      |=> (slot_valid[BUF_DAT] && slot_tag[BUF_DAT] == $past(busy_tag)));

endmodule

// File: tb/flash_line_accel_bench.sv
module flash_line_accel_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TAG_W      = 28;
   localparam int LINE_W     = 128;
   localparam logic [31:0] PAT_KEY = 32'hC3A5_0000;

   logic               clk;
   logic               rst_n;
   logic               cfg_enable;
   logic [3:0]         cfg_access_clks;
   logic               rd_valid;
   logic [31:0]        rd_addr;
   logic               rd_is_instr;
   logic               rd_is_seq;
   logic [31:0]        rd_data;
   logic               rd_ready;
   logic               fl_req;
   logic [TAG_W-1:0]   fl_line_addr;
   logic [LINE_W-1:0]  fl_rdata;

   flash_line_accel u_flash_line_accel (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_enable      (cfg_enable),
      .cfg_access_clks (cfg_access_clks),
      .rd_valid        (rd_valid),
      .rd_addr         (rd_addr),
      .rd_is_instr     (rd_is_instr),
      .rd_is_seq       (rd_is_seq),
      .rd_data         (rd_data),
      .rd_ready        (rd_ready),
      .fl_req          (fl_req),
      .fl_line_addr    (fl_line_addr),
      .fl_rdata        (fl_rdata)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   // behavioural flash: line valid only in the T-th cycle of an access
   function automatic logic [LINE_W-1:0] line_pat(input logic [TAG_W-1:0] ln);
      logic [LINE_W-1:0] r;
      for (int w = 0; w < 4; w++) begin
         r[w*32 +: 32] = {ln, 2'(w), 2'b00} ^ PAT_KEY;
      end
      return r;
   endfunction

   logic [3:0]       fcnt;
   logic [TAG_W-1:0] fline;

   always @(posedge clk) begin
      if (!rst_n) begin
         fcnt  <= '0;
         fline <= '0;
      end else if (fl_req) begin
         fcnt  <= cfg_access_clks - 4'd1;
         fline <= fl_line_addr;
      end else if (fcnt != 0) begin
         fcnt <= fcnt - 4'd1;
      end
   end

   assign fl_rdata = (fcnt == 4'd1) ? line_pat(fline) : {4{32'hBAD0_BAD0}};

   // request monitor
   int               req_cnt;
   logic [TAG_W-1:0] last_line;

   initial begin
      req_cnt   = 0;
      last_line = '0;
   end

   always @(negedge clk) begin
      if (rst_n && fl_req) begin
         req_cnt   = req_cnt + 1;
         last_line = fl_line_addr;
      end
   end

   int checks;
   int errors;

   task automatic expect_eq(input string req, input string what,
                            input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      @(posedge clk);
      #2;
      rd_valid = 1'b0;
      for (int i = 1; i < n; i++) @(posedge clk);
   endtask

   // one read held until ready; checks the wait count and the word
   task automatic read_chk(input string req, input logic [31:0] a,
                           input logic instr, input logic seq, input int exp_waits);
      int          waits;
      logic [31:0] got;
      @(posedge clk);
      #2;
      rd_valid    = 1'b1;
      rd_addr     = a;
      rd_is_instr = instr;
      rd_is_seq   = seq;
      waits       = 0;
      got         = '0;
      forever begin
         @(negedge clk);
         if (rd_ready) begin
            got = rd_data;
            break;
         end
         waits++;
         if (waits > 60) break;
      end
      expect_eq(req, $sformatf("wait states @%0h", a), waits, exp_waits);
      expect_eq(req, $sformatf("data @%0h", a), got, a ^ PAT_KEY);
   endtask

   task automatic t_reset;
      rst_n           = 1'b0;
      rd_valid        = 1'b0;
      rd_addr         = '0;
      rd_is_instr     = 1'b1;
      rd_is_seq       = 1'b0;
      cfg_enable      = 1'b1;
      cfg_access_clks = 4'd3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      expect_eq("R11", "rd_ready in reset", rd_ready, 0);
      expect_eq("R11", "fl_req in reset", fl_req, 0);
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      idle(3);
      expect_eq("R11", "no request after reset while idle", req_cnt, 0);
   endtask

   task automatic t_miss_hit;
      int snap;
      // R2 R11: first read after reset misses, R1 line address
      read_chk("R2", 32'h0000_1008, 1'b1, 1'b0, 2);
      expect_eq("R1", "line address", last_line, 28'h100);
      expect_eq("R1", "one request", req_cnt, 1);
      idle(6);
      snap = req_cnt;
      // R3 R4: hits in the held line, every word position
      read_chk("R3", 32'h0000_1000, 1'b1, 1'b0, 0);
      read_chk("R4", 32'h0000_1004, 1'b1, 1'b1, 0);
      read_chk("R4", 32'h0000_100C, 1'b1, 1'b1, 0);
      idle(1);
      expect_eq("R3", "no request on hits", req_cnt, snap);
   endtask

   task automatic t_stream;
      idle(6);
      read_chk("R5", 32'h0000_2000, 1'b1, 1'b0, 2);
      for (int k = 1; k < 16; k++) begin
         read_chk("R5", 32'h0000_2000 + 32'(4 * k), 1'b1, 1'b1, 0);
      end
   endtask

   task automatic t_data_buf;
      idle(6);
      read_chk("R6", 32'h0000_3008, 1'b0, 1'b0, 2);
      read_chk("R6", 32'h0000_300C, 1'b0, 1'b0, 0);
      read_chk("R6", 32'h0000_3000, 1'b0, 1'b0, 0);
      idle(6);
      // instruction registers untouched by data reads
      read_chk("R6", 32'h0000_3004, 1'b1, 1'b0, 2);
      idle(6);
      read_chk("R6", 32'h0000_5000, 1'b0, 1'b0, 2);
      idle(6);
      read_chk("R6", 32'h0000_3000, 1'b0, 1'b0, 2);
   endtask

   task automatic t_branch;
      idle(6);
      read_chk("R7", 32'h0000_4000, 1'b1, 1'b0, 2);
      for (int pass = 0; pass < 2; pass++) begin
         for (int k = 1; k < 8; k++) begin
            read_chk("R7", 32'h0000_4000 + 32'(4 * k), 1'b1, 1'b1, 0);
         end
         read_chk("R7", 32'h0000_4000, 1'b1, 1'b0, 0);
      end
      idle(6);
      read_chk("R7", 32'h0000_5800, 1'b1, 1'b0, 2);
      idle(6);
      read_chk("R7", 32'h0000_4000, 1'b1, 1'b0, 2);
   endtask

   task automatic t_pf_other;
      int snap;
      idle(6);
      read_chk("R8", 32'h0000_6000, 1'b1, 1'b0, 2);
      snap = req_cnt;
      idle(1);
      read_chk("R8", 32'h0000_7004, 1'b0, 1'b0, 4);
      expect_eq("R8", "prefetch then demand requests", req_cnt, snap + 2);
      expect_eq("R8", "demand line follows prefetch", last_line, 28'h700);
   endtask

   task automatic t_pf_same;
      int snap;
      idle(6);
      read_chk("R9", 32'h0000_6800, 1'b1, 1'b0, 2);
      snap = req_cnt;
      idle(1);
      read_chk("R9", 32'h0000_6814, 1'b0, 1'b0, 1);
      expect_eq("R9", "no extra request", req_cnt, snap + 1);
      read_chk("R9", 32'h0000_6818, 1'b0, 1'b0, 0);
      read_chk("R9", 32'h0000_6810, 1'b1, 1'b1, 0);
   endtask

   task automatic t_disable;
      int snap;
      idle(6);
      cfg_enable = 1'b0;
      snap = req_cnt;
      read_chk("R10", 32'h0000_6800, 1'b1, 1'b0, 2);
      read_chk("R10", 32'h0000_6800, 1'b1, 1'b0, 2);
      idle(8);
      expect_eq("R10", "only demand requests while off", req_cnt, snap + 2);
      cfg_enable = 1'b1;
      read_chk("R10", 32'h0000_6804, 1'b1, 1'b0, 2);
   endtask

   task automatic t_slow;
      idle(6);
      cfg_access_clks = 4'd5;
      idle(2);
      read_chk("R12", 32'h0000_7800, 1'b1, 1'b0, 4);
      idle(8);
      cfg_access_clks = 4'd3;
      idle(2);
   endtask

   initial begin
      checks = 0;
      errors = 0;
      t_reset();
      t_miss_hit();
      t_stream();
      t_data_buf();
      t_branch();
      t_pf_other();
      t_pf_same();
      t_disable();
      t_slow();
      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule